// File: doc/BRIEF.md
# Cascadable 1-Wire Time-Slot Engine

This block generates 1-Wire bus waveforms in hardware for a host that reaches it through a narrow, printer-style parallel port. The host sets a reset-request line, a data/clock line and a speed-select line, then pulses a trigger. On that trigger the block captures all three lines and produces one of three waveforms on an open-drain bus: a reset/presence sequence, a write-1 (or read) slot, or a write-0 slot. Once the capture is made, other traffic on the shared port cannot disturb the slot in progress. Every duration is derived from the `CLK_HZ` parameter. Each slot runs at either standard or overdrive speed.

Two status outputs first signal that a slot is in progress and then carry its result. The host can do other work and poll the status lines afterwards. Several units can be chained. A unit whose enable input is low copies its two status inputs to its two status outputs, so the status of units further down the chain (and finally the printer's busy/select lines) reaches the host port. All interfaces are plain control and status pins. There is no valid/ready stream, and therefore no back-pressure: a trigger that arrives while a slot runs is dropped.

Top module: `owire_slot_engine`

## Requirements
- R1: After reset, with `en_in` high, `stat_out1` = 1, `stat_out2` = 1 and `bus_pull_low` = 0.
- R2: A trigger with `host_rst` = 1 and `od_sel` = 0 starts a reset sequence. The bus is driven low for 480 µs and then released. The bus is sampled 70 µs after the release, and the whole sequence lasts 960 µs.
- R3: The same sequence with `od_sel` = 1 drives the bus low for 48 µs, samples 8 µs after the release, and lasts 96 µs.
- R4: A trigger with `host_rst` = 0 and `host_dc` = 1 gives a write-1/read slot. At standard speed the bus is low for 6 µs, sampled at 15 µs and the slot lasts 70 µs. At overdrive these times are 1 µs, 2 µs and 10 µs.
- R5: A trigger with `host_rst` = 0 and `host_dc` = 0 gives a write-0 slot. The bus is low for 60 µs (standard) or 7.5 µs (overdrive), and the slot lasts 70 µs or 10 µs. `host_rst` = 1 takes priority over `host_dc`.
- R6: While a slot runs and `en_in` is high, both status outputs read 0. Every completed state has at least one status output at 1.
- R7: After a reset sequence, `stat_out1` = 1. `stat_out2` = 1 if the bus was low at the presence sample (a device answered) and 0 otherwise.
- R8: After a write or read slot, `stat_out1` equals the bus level sampled in that slot and `stat_out2` = 1.
- R9: Once a slot has started, changes to `host_rst`, `host_dc` or `od_sel` and further trigger pulses have no effect on it: its kind, speed and duration stay as captured.
- R10: While `en_in` is low, `stat_out1`/`stat_out2` follow `stat_in1`/`stat_in2`, triggers are ignored, the bus stays released, and `en_out` follows `en_in`.
- R11: The bus is released before the slot's status clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency `CLK_HZ` |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_in | input | 1 | Chain enable from the previous unit or the host |
| host_go | input | 1 | One-cycle trigger that captures the host lines and starts a slot |
| host_rst | input | 1 | Reset-sequence request |
| host_dc | input | 1 | Data bit for the slot (1 = write-1/read, 0 = write-0) |
| od_sel | input | 1 | Overdrive speed select |
| stat_in1 | input | 1 | Status 1 from the next unit downstream |
| stat_in2 | input | 1 | Status 2 from the next unit downstream |
| stat_out1 | output | 1 | Busy/result 1 towards the host side |
| stat_out2 | output | 1 | Busy/result 2 towards the host side |
| en_out | output | 1 | Enable towards the next unit |
| bus_in | input | 1 | Sensed level of the 1-Wire line |
| bus_pull_low | output | 1 | Open-drain pull-down request for the 1-Wire line |

## Verification
The bench runs reset sequences at both speeds, once with a presence pulse whose window straddles the sample point and once with no answer. This shows that presence is sampled at the stated instant and not merely anywhere during the release. Read slots use a device pull-down that ends either just after or just before the 15 µs sample point, which separates a correct sample time from one that is too early or too late. The bench measures the low time and the total busy length of every slot and compares them with the standard and overdrive figures. Mid-slot toggles of the host lines, and a disabled unit with pass-through status, show that captured controls hold and that the chain mirror is isolated from the slot engine.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    SK_RESET  = 2'd0,
    SK_WRITE1 = 2'd1,
    SK_WRITE0 = 2'd2
  } slot_kind_e;

  // Converts a duration in nanoseconds to a number of clock cycles.
  function automatic longint ns_to_cyc(longint hz, longint ns);
    return (hz * ns) / 64'd1_000_000_000;
  endfunction
endpackage

// File: rtl/ow_timing.sv
module ow_timing
  import ow_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int CW     = 16
) (
  input  slot_kind_e    kind,
  input  logic          od,
  output logic [CW-1:0] t_low,
  output logic [CW-1:0] t_samp,
  output logic [CW-1:0] t_end
);
  localparam int RST_LOW_S = int'(ns_to_cyc(CLK_HZ, 480_000));
  localparam int RST_LOW_O = int'(ns_to_cyc(CLK_HZ, 48_000));
  localparam int RST_PD_S  = int'(ns_to_cyc(CLK_HZ, 70_000));
  localparam int RST_PD_O  = int'(ns_to_cyc(CLK_HZ, 8_000));
  localparam int RST_END_S = int'(ns_to_cyc(CLK_HZ, 960_000));
  localparam int RST_END_O = int'(ns_to_cyc(CLK_HZ, 96_000));
  localparam int W1_LOW_S  = int'(ns_to_cyc(CLK_HZ, 6_000));
  localparam int W1_LOW_O  = int'(ns_to_cyc(CLK_HZ, 1_000));
  localparam int W0_LOW_S  = int'(ns_to_cyc(CLK_HZ, 60_000));
  localparam int W0_LOW_O  = int'(ns_to_cyc(CLK_HZ, 7_500));
  localparam int BIT_SMP_S = int'(ns_to_cyc(CLK_HZ, 15_000));
  localparam int BIT_SMP_O = int'(ns_to_cyc(CLK_HZ, 2_000));
  localparam int BIT_END_S = int'(ns_to_cyc(CLK_HZ, 70_000));
  localparam int BIT_END_O = int'(ns_to_cyc(CLK_HZ, 10_000));

  always_comb begin
    case (kind)
      SK_RESET: begin
        t_low  = od ? CW'(RST_LOW_O) : CW'(RST_LOW_S);
        t_samp = od ? CW'(RST_LOW_O + RST_PD_O) : CW'(RST_LOW_S + RST_PD_S);
        t_end  = od ? CW'(RST_END_O) : CW'(RST_END_S);
      end
      SK_WRITE0: begin
        t_low  = od ? CW'(W0_LOW_O) : CW'(W0_LOW_S);
        t_samp = od ? CW'(BIT_SMP_O) : CW'(BIT_SMP_S);
        t_end  = od ? CW'(BIT_END_O) : CW'(BIT_END_S);
      end
      default: begin
        t_low  = od ? CW'(W1_LOW_O) : CW'(W1_LOW_S);
        t_samp = od ? CW'(BIT_SMP_O) : CW'(BIT_SMP_S);
        t_end  = od ? CW'(BIT_END_O) : CW'(BIT_END_S);
      end
    endcase
  end
endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
  import ow_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  slot_kind_e    kind_in,
  input  logic          od_in,
  input  logic          bus_in,
  input  logic [CW-1:0] t_low,
  input  logic [CW-1:0] t_samp,
  input  logic [CW-1:0] t_end,
  output logic          busy,
  output logic          last,
  output logic          drive_low,
  output slot_kind_e    kind_q,
  output logic          od_q,
  output logic          smp_q
);
  logic [CW-1:0] cnt;

  assign last      = busy && (cnt == t_end - 1'b1);
  assign drive_low = busy && (cnt < t_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      kind_q <= SK_WRITE1;
      od_q   <= 1'b0;
      smp_q  <= 1'b1;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        kind_q <= kind_in;
        od_q   <= od_in;
      end
    end else begin
      if (cnt == t_samp) smp_q <= bus_in;
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end

  // R9
  hold_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(od_q) && $stable(kind_q)));

  // R11
  release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(drive_low));
endmodule

// File: rtl/ow_status_port.sv
module ow_status_port
  import ow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_in,
  input  logic       busy,
  input  logic       last,
  input  slot_kind_e kind_q,
  input  logic       smp_q,
  input  logic       stat_in1,
  input  logic       stat_in2,
  output logic       stat_out1,
  output logic       stat_out2
);
  logic res1, res2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res1 <= 1'b1;
      res2 <= 1'b1;
    end else if (last) begin
      if (kind_q == SK_RESET) begin
        res1 <= 1'b1;
        res2 <= !smp_q;
      end else begin
        res1 <= smp_q;
        res2 <= 1'b1;
      end
    end
  end

  always_comb begin
    if (!en_in) begin
      stat_out1 = stat_in1;
      stat_out2 = stat_in2;
    end else if (busy) begin
      stat_out1 = 1'b0;
      stat_out2 = 1'b0;
    end else begin
      stat_out1 = res1;
      stat_out2 = res2;
    end
  end

  // R6
  done_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_in && !busy) |-> (stat_out1 || stat_out2));
endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
  import ow_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  input  logic host_go,
  input  logic host_rst,
  input  logic host_dc,
  input  logic od_sel,
  input  logic stat_in1,
  input  logic stat_in2,
  output logic stat_out1,
  output logic stat_out2,
  output logic en_out,
  input  logic bus_in,
  output logic bus_pull_low
);
  localparam longint MAX_CYC = ns_to_cyc(CLK_HZ, 960_000);
  localparam int     CW      = $clog2(MAX_CYC + 1) + 1;

  slot_kind_e    kind_in, kind_q;
  logic          od_q, busy, last, smp_q, start;
  logic [CW-1:0] t_low, t_samp, t_end;

  assign start   = host_go && en_in;
  assign kind_in = host_rst ? SK_RESET : (host_dc ? SK_WRITE1 : SK_WRITE0);
  assign en_out  = en_in;

  ow_timing #(.CLK_HZ(CLK_HZ), .CW(CW)) u_timing (
    .kind(kind_q), .od(od_q), .t_low(t_low), .t_samp(t_samp), .t_end(t_end)
  );

  ow_slot_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .kind_in(kind_in), .od_in(od_sel),
    .bus_in(bus_in), .t_low(t_low), .t_samp(t_samp), .t_end(t_end),
    .busy(busy), .last(last), .drive_low(bus_pull_low), .kind_q(kind_q),
    .od_q(od_q), .smp_q(smp_q)
  );

  ow_status_port u_status (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .busy(busy), .last(last),
    .kind_q(kind_q), .smp_q(smp_q), .stat_in1(stat_in1), .stat_in2(stat_in2),
    .stat_out1(stat_out1), .stat_out2(stat_out2)
  );

  // R10
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_go && en_in));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_pull_low);

  // R6
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_in && busy) |-> (!stat_out1 && !stat_out2));
endmodule

// File: tb/tb_owire_slot_engine.sv
module tb_owire_slot_engine;
  localparam int CLK = 10_000_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_in = 1'b1, host_go = 1'b0, host_rst = 1'b0, host_dc = 1'b0, od_sel = 1'b0;
  logic stat_in1 = 1'b1, stat_in2 = 1'b1;
  logic stat_out1, stat_out2, en_out, bus_pull_low, bus_in;
  logic slave_pull = 1'b0;

  int n_chk = 0, n_err = 0, done_cnt = 0;

  typedef struct {
    int    lowc, busyc, o1, o2, wlo, whi;
    string req;
  } exp_t;
  exp_t q[$];

  assign bus_in = !(bus_pull_low || slave_pull);

  always #2 clk = ~clk;

  owire_slot_engine #(.CLK_HZ(CLK)) dut (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .host_go(host_go),
    .host_rst(host_rst), .host_dc(host_dc), .od_sel(od_sel),
    .stat_in1(stat_in1), .stat_in2(stat_in2), .stat_out1(stat_out1),
    .stat_out2(stat_out2), .en_out(en_out), .bus_in(bus_in),
    .bus_pull_low(bus_pull_low)
  );

  function automatic int cyc(longint ns);
    return int'((longint'(CLK) * ns) / 64'd1_000_000_000);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures every slot seen at the ports and compares it with the queue head.
  bit in_slot = 0;
  int k = 0, lowc = 0;
  always @(negedge clk) begin
    if (en_in && !stat_out1 && !stat_out2) begin
      if (!in_slot) begin in_slot = 1; k = 0; lowc = 0; end
      if (bus_pull_low) lowc++;
      if (q.size() > 0) slave_pull <= (k >= q[0].wlo) && (k < q[0].whi);
      k++;
    end else begin
      slave_pull <= 1'b0;
      if (in_slot) begin
        exp_t e;
        in_slot = 0;
        if (q.size() == 0) chk(0, "queue", 0, 1);
        else begin
          e = q.pop_front();
          chk(lowc == e.lowc, {e.req, " low time"}, lowc, e.lowc);
          chk(k == e.busyc, {e.req, " slot length"}, k, e.busyc);
          chk(stat_out1 == e.o1, {e.req, " stat_out1"}, stat_out1, e.o1);
          chk(stat_out2 == e.o2, {e.req, " stat_out2"}, stat_out2, e.o2);
        end
        done_cnt++;
      end
    end
  end

  // Driver: computes expectations from the requirements, queues them, triggers the slot.
  task automatic run_slot(input bit r, input bit dc, input bit od,
                          input int wlo, input int whi, input bit mess, input string req);
    exp_t e;
    int old, smp;
    e.req = req; e.wlo = wlo; e.whi = whi;
    if (r) begin
      e.lowc  = od ? cyc(48_000) : cyc(480_000);
      smp     = e.lowc + (od ? cyc(8_000) : cyc(70_000));
      e.busyc = od ? cyc(96_000) : cyc(960_000);
      e.o1 = 1;
      e.o2 = (smp >= wlo && smp < whi) ? 1 : 0;
    end else begin
      e.lowc  = dc ? (od ? cyc(1_000) : cyc(6_000)) : (od ? cyc(7_500) : cyc(60_000));
      smp     = od ? cyc(2_000) : cyc(15_000);
      e.busyc = od ? cyc(10_000) : cyc(70_000);
      e.o1 = (!dc || smp < e.lowc || (smp >= wlo && smp < whi)) ? 0 : 1;
      e.o2 = 1;
    end
    q.push_back(e);
    old = done_cnt;
    @(negedge clk);
    host_rst = r; host_dc = dc; od_sel = od; host_go = 1'b1;
    @(negedge clk);
    host_go = 1'b0;
    if (mess) begin
      repeat (4) @(negedge clk);
      host_rst = !r; host_dc = !dc; od_sel = !od; host_go = 1'b1;
      @(negedge clk);
      host_go = 1'b0;
    end
    while (done_cnt == old) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat_out1 == 1'b1, "R1 stat_out1", stat_out1, 1);
    chk(stat_out2 == 1'b1, "R1 stat_out2", stat_out2, 1);
    chk(bus_pull_low == 1'b0, "R1 bus released", bus_pull_low, 0);

    // R2 / R7: presence window straddling the 70 us sample, then no device.
    base = cyc(480_000);
    run_slot(1, 0, 0, base + cyc(60_000), base + cyc(80_000), 0, "R2 R7 reset std");
    run_slot(1, 0, 0, 0, 0, 0, "R7 reset no presence");
    // R3: overdrive reset with presence window around 8 us.
    base = cyc(48_000);
    run_slot(1, 1, 1, base + cyc(6_000), base + cyc(10_000), 0, "R3 reset od");
    // R4 / R8: device holds low past the 15 us sample, then releases before it.
    run_slot(0, 1, 0, 0, cyc(17_000), 0, "R4 R8 read 0 std");
    run_slot(0, 1, 0, 0, cyc(13_000), 0, "R4 R8 read 1 std");
    run_slot(0, 1, 1, 0, cyc(4_000), 0, "R4 read 0 od");
    // R5: write-0 at both speeds; host_rst priority checked by r=1,dc=0 above.
    run_slot(0, 0, 0, 0, 0, 0, "R5 write0 std");
    // R9: host lines and trigger toggled mid-slot.
    run_slot(0, 0, 1, 0, 0, 1, "R5 R9 write0 od");
    run_slot(0, 1, 0, 0, 0, 1, "R9 write1 std");

    // R10: disabled unit mirrors the chain and ignores triggers.
    @(negedge clk);
    en_in = 1'b0; stat_in1 = 1'b0; stat_in2 = 1'b1;
    @(negedge clk);
    chk(stat_out1 == 1'b0 && stat_out2 == 1'b1, "R10 mirror a",
        {stat_out1, stat_out2}, 2'b01);
    chk(en_out == 1'b0, "R10 en_out low", en_out, 0);
    stat_in1 = 1'b1; stat_in2 = 1'b0;
    host_rst = 1'b1; host_go = 1'b1;
    @(negedge clk);
    host_go = 1'b0;
    chk(stat_out1 == 1'b1 && stat_out2 == 1'b0, "R10 mirror b",
        {stat_out1, stat_out2}, 2'b10);
    begin
      bit any_low = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (bus_pull_low) any_low = 1;
      end
      chk(any_low == 0, "R10 bus released while disabled", any_low, 0);
    end
    en_in = 1'b1;
    @(negedge clk);
    chk(en_out == 1'b1, "R10 en_out follows", en_out, 1);
    chk(stat_out1 == 1'b1 && stat_out2 == 1'b1, "R10 no slot started",
        {stat_out1, stat_out2}, 2'b11);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule